// File: doc/BRIEF.md
# Tree-structured 1:16 serial deserializer

The block takes one serial bit on every cycle of a full-rate clock and turns each group of sixteen consecutive bits into one 16-bit parallel word. It does not use a flat shift register. A chain of four cascaded divide-by-2 stages times a binary tree of 1:2 splitting levels. The first level steers alternate bits into two lanes. Each later level doubles the lane count: two lanes become four, four become eight, and eight become sixteen. Each level writes only on the phase of its own divided clock. All registers sit in the single full-rate clock domain and use the divider bits as enables.

Words leave the block with a one-cycle strobe, once for every sixteen input bits. The serial side has no handshake: one bit enters on every clock edge outside reset. The word side has a valid strobe and no ready, so the block cannot be held back. The consumer must take each word within the sixteen cycles that it is held. A static bit-order input chooses which end of the word holds the earliest-received bit. The decoding assumes nothing about transition density, so long runs of constant data are handled like any other pattern.

Top module: `deser_tree16`

## Requirements
- R1: Outside reset, `word_vld` is high for exactly one cycle. Once the first word has appeared, it is high once every 16 cycles.
- R2: After `rst` falls, the first rising edge with `rst` low samples bit 0 of group 0. Number that edge 0. Group s is presented after edge 16s+19, which is four edges after its last bit is sampled. `word_vld` stays low before the edge that presents group 0.
- R3: With `msb_hi` low, `word_out[0]` holds the earliest bit of the group and `word_out[15]` holds the latest. Bit j of the group appears on `word_out[j]`.
- R4: With `msb_hi` high, `word_out[15]` holds the earliest bit of the group and `word_out[0]` holds the latest. Bit j of the group appears on `word_out[15-j]`.
- R5: A word is ordered by the level of `msb_hi` at the edge that presents it. A change of `msb_hi` at any other moment has no effect on the word already presented.
- R6: `word_out` does not change in any cycle in which `word_vld` is low.
- R7: Constant input streams are handled. An all-zero stream gives 0x0000 and an all-one stream gives 0xFFFF, in either bit order.
- R8: While `rst` is high, `word_out` is 0 and `word_vld` is 0 from the following edge on. After `rst` falls, group alignment restarts as R2 states, even when reset is applied in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data, one bit per clock |
| msb_hi | input | 1 | Bit order: 0 puts the earliest bit on bit 0, 1 puts it on bit 15 |
| word_out | output | 16 | Parallel word, held between strobes |
| word_vld | output | 1 | One-cycle strobe marking a new word |

## Verification
Two events can land on the same edge: the presentation of a word and a flip of `msb_hi`. The bench flips the order input every few cycles with a period that is coprime to 16, so that some flips hit a presenting edge and others fall mid-group. The reference model orders each word by the level it samples at that same edge. Reset is also raised in the middle of a group. The bench then checks that the latency count restarts from the release edge and that no partial word is presented.

// File: rtl/deser_pkg.sv
package deser_pkg;
  // default tree depth: 2**4 = 16 lanes
  localparam int unsigned DEF_LEVELS = 4;

  // phase of the divider count at which the deepest level becomes readable
  function automatic int unsigned word_ready_phase(input int unsigned levels);
    return levels - 1;
  endfunction
endpackage

// File: rtl/deser_divchain.sv
module deser_divchain #(
  parameter int unsigned LEVELS = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [LEVELS-1:0] phase
);
  // each stage toggles when all stages below it are high (cascaded /2)
  logic [LEVELS-1:0] carry;

  assign carry[0] = 1'b1;

  for (genvar k = 0; k < LEVELS; k++) begin : g_stage
    if (k > 0) begin : g_carry
      assign carry[k] = carry[k-1] & phase[k-1];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        phase[k] <= 1'b0;
      end else if (carry[k]) begin
        phase[k] <= ~phase[k];
      end
    end
  end
endmodule

// File: rtl/deser_split_level.sv
module deser_split_level #(
  parameter int unsigned LVL = 1,
  localparam int unsigned HALF = 1 << (LVL - 1),
  localparam int unsigned FULL = 1 << LVL
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LVL-1:0]  phase,
  input  logic [HALF-1:0] din,
  output logic [FULL-1:0] dout
);
  logic fire;
  logic upper;

  if (LVL == 1) begin : g_first
    // alternate bits: even index to lane 0, odd index to lane 1
    assign fire  = 1'b1;
    assign upper = phase[0];
  end else begin : g_deeper
    // the level below is readable when its low phase bits equal LVL-2
    assign fire  = (phase[LVL-2:0] == (LVL-1)'(LVL - 2));
    assign upper = ~phase[LVL-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (fire) begin
      if (upper) begin
        dout[FULL-1:HALF] <= din;
      end else begin
        dout[HALF-1:0] <= din;
      end
    end
  end
endmodule

// File: rtl/deser_word_out.sv
module deser_word_out
  import deser_pkg::*;
#(
  parameter int unsigned LEVELS = 4,
  localparam int unsigned W = 1 << LEVELS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEVELS-1:0] phase,
  input  logic              msb_hi,
  input  logic [W-1:0]      tree_word,
  output logic [W-1:0]      word_out,
  output logic              word_vld
);
  localparam logic [LEVELS-1:0] READY_PH = LEVELS'(word_ready_phase(LEVELS));

  logic         primed;
  logic         load;
  logic [W-1:0] flipped;

  // first pass of the divider holds no complete group
  always_ff @(posedge clk) begin
    if (rst) begin
      primed <= 1'b0;
    end else if (&phase) begin
      primed <= 1'b1;
    end
  end

  assign load = primed && (phase == READY_PH);

  for (genvar j = 0; j < W; j++) begin : g_flip
    assign flipped[j] = tree_word[W-1-j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= load;
      if (load) begin
        word_out <= msb_hi ? flipped : tree_word;
      end
    end
  end
endmodule

// File: rtl/deser_tree16.sv
module deser_tree16
  import deser_pkg::*;
#(
  parameter int unsigned LEVELS = DEF_LEVELS,
  localparam int unsigned W = 1 << LEVELS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_in,
  input  logic         msb_hi,
  output logic [W-1:0] word_out,
  output logic         word_vld
);
  // level L occupies bits [2**L-1 +: 2**L]; level 0 is the serial bit
  localparam int unsigned BUS_W = 2 * W - 1;

  logic [LEVELS-1:0] div_phase;
  logic [BUS_W-1:0]  tree_bus;

  deser_divchain #(.LEVELS(LEVELS)) u_div (
    .clk   (clk),
    .rst   (rst),
    .phase (div_phase)
  );

  assign tree_bus[0] = ser_in;

  for (genvar L = 1; L <= LEVELS; L++) begin : g_level
    deser_split_level #(.LVL(L)) u_split (
      .clk   (clk),
      .rst   (rst),
      .phase (div_phase[L-1:0]),
      .din   (tree_bus[(1 << (L - 1)) - 1 +: (1 << (L - 1))]),
      .dout  (tree_bus[(1 << L) - 1 +: (1 << L)])
    );
  end

  deser_word_out #(.LEVELS(LEVELS)) u_out (
    .clk       (clk),
    .rst       (rst),
    .phase     (div_phase),
    .msb_hi    (msb_hi),
    .tree_word (tree_bus[W-1 +: W]),
    .word_out  (word_out),
    .word_vld  (word_vld)
  );
endmodule

// File: rtl/deser_tree16_chk.sv
module deser_tree16_chk #(
  parameter int unsigned LEVELS = 4,
  localparam int unsigned W = 1 << LEVELS,
  localparam int unsigned CW = $clog2(W + LEVELS) + 2
) (
  input logic              clk,
  input logic              rst,
  input logic [LEVELS-1:0] phase,
  input logic [W-1:0]      word_out,
  input logic              word_vld
);
  localparam logic [CW-1:0] GAP_EXP   = CW'(W - 1);
  localparam logic [CW-1:0] FIRST_EXP = CW'(W + LEVELS);

  logic [CW-1:0] gap;
  logic [CW-1:0] since_rst;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap       <= '0;
      since_rst <= '0;
      seen      <= 1'b0;
    end else begin
      if (since_rst != '1) since_rst <= since_rst + 1'b1;
      if (word_vld) begin
        gap  <= '0;
        seen <= 1'b1;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R1
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);

  // R1
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (word_vld && seen) |-> (gap == GAP_EXP));

  // R2
  first_word_chk: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !seen) |-> (since_rst == FIRST_EXP));

  // R2
  div_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (phase[0] != $past(phase[0])));

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !word_vld |-> $stable(word_out));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (word_out == '0 && !word_vld));
endmodule

bind deser_tree16 deser_tree16_chk #(.LEVELS(LEVELS)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .phase    (div_phase),
  .word_out (word_out),
  .word_vld (word_vld)
);

// File: tb/test_deser_tree16.sv
module test_deser_tree16;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_in = 1'b0;
  logic        msb_hi = 1'b0;
  logic [15:0] word_out;
  logic        word_vld;

  always #4 clk = ~clk;

  deser_tree16 i_deser_tree16 (
    .clk      (clk),
    .rst      (rst),
    .ser_in   (ser_in),
    .msb_hi   (msb_hi),
    .word_out (word_out),
    .word_vld (word_vld)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: bit history queue and edge count since reset
  int          e_cnt = 0;
  bit          hist[$];
  logic [15:0] exp_w = '0;
  logic        exp_v = 1'b0;
  string       exp_tag = "R8";
  string       phase_tag = "";
  bit          started = 1'b0;

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      e_cnt = 0;
      hist.delete();
      exp_w = '0;
      exp_v = 1'b0;
      exp_tag = "R8";
    end else begin
      hist.push_back(ser_in);
      exp_v = 1'b0;
      // R2: group s presented after edge 16s+19
      if (e_cnt >= 19 && (e_cnt - 19) % 16 == 0) begin
        int s;
        s = (e_cnt - 19) / 16;
        for (int j = 0; j < 16; j++) begin
          // R3 / R4: earliest bit on bit 0 or on bit 15
          exp_w[msb_hi ? 15 - j : j] = hist[16 * s + j];
        end
        exp_v = 1'b1;
        exp_tag = (phase_tag != "") ? phase_tag : (msb_hi ? "R4" : "R3");
      end
      e_cnt++;
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      chk(word_vld === exp_v, (!rst && e_cnt <= 20) ? "R2" : (rst ? "R8" : "R1"),
          {15'd0, word_vld}, {15'd0, exp_v});
      chk(word_out === exp_w, rst ? "R8" : (exp_v ? exp_tag : "R6"),
          word_out, exp_w);
    end
  end

  task automatic drive(input int n, input int kind, input int flip);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (kind)
        0: begin
          lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          ser_in = lfsr[0];
        end
        1:       ser_in = 1'b0;
        default: ser_in = 1'b1;
      endcase
      if (flip != 0 && i % flip == 0) msb_hi = ~msb_hi;
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    msb_hi = 1'b0;
    drive(80, 0, 0);           // R3 pseudo-random data
    msb_hi = 1'b1;
    drive(96, 0, 0);           // R4
    phase_tag = "R5";
    drive(112, 0, 7);          // order flips hitting and missing load edges
    phase_tag = "R7";
    drive(48, 1, 0);           // all zeros
    drive(64, 2, 5);           // all ones with order flipping
    phase_tag = "";
    drive(11, 0, 0);
    rst = 1'b1;                // R8 reset mid-group
    drive(3, 0, 0);
    rst = 1'b0;
    drive(70, 0, 0);
    summary();
  end

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule